// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a shared on-chip scratchpad that serves a group of parallel lanes at once. Its storage is split into word-interleaved banks: consecutive 32-bit words fall in consecutive banks and wrap around after the last one. Every lane presents one request per group, made of a valid bit, a write enable, a byte address and 32-bit write data. The block works out which lanes land in the same bank and serves them over as many passes as the most heavily contended bank needs. Lanes that land in distinct banks all finish in a single pass.

A group is taken in with a start strobe while the block is idle. The whole request set is captured at that point, and `busy` stays high until the group is finished. In every pass, each bank serves the lowest-numbered lane still waiting on it. Writes land in that pass. Reads return their data a fixed four cycles after the pass that served them, with a one-cycle per-lane valid. A single-cycle `done` pulse marks the end of the group, and it lines up with the last possible read return.

A 32-lane thread group is presented as two back-to-back half-groups of 16 lanes.

Top module: `sp_banked_scratch`

## Requirements
- R1: Address mapping. A lane's byte address bits [5:2] pick the bank, bits [13:6] pick the 32-bit entry inside that bank, and bits [1:0] are ignored. Sixteen consecutive words starting at any word, including a run that wraps from bank 15 to bank 0, fall in distinct banks.
- R2: A group is accepted only when `grp_start` is high while `busy` is low. A start that arrives while `busy` is high has no effect, and its writes do not reach memory.
- R3: A group in which every valid lane hits a different bank finishes in one pass. `done` is high in cycle 5, where the cycle in which the group is accepted is cycle 0.
- R4: Lanes that share a bank are serialized. The number of passes N equals the largest number of valid lanes that target any single bank, and `done` is high in cycle N+4. A group with no valid lanes has N=0.
- R5: In each pass, every bank serves its lowest-numbered waiting lane. Among lanes that hit the same word, a lower lane's write is therefore seen by a higher lane's read in the same group, and a lower lane's read returns the value from before a higher lane's write.
- R6: A read served in pass p (counted from 1) raises that lane's `rd_valid` bit for exactly one cycle, in cycle p+4, and carries the word in `rd_data`. Lanes that write produce no `rd_valid`.
- R7: When several lanes of one group write the same word, the highest-numbered lane's data is what remains in memory.
- R8: `busy` is high from cycle 1 through the cycle in which `done` is high, and it is low in the cycle after. `done` is a single-cycle pulse.
- R9: While reset is held, and right after it, `busy`, `done` and every `rd_valid` bit are low. Memory contents are not initialized.
- R10: A lane whose valid bit is low is ignored. It writes nothing, returns no read, and does not add to the pass count.
- R11: Every pass serves at least one waiting lane, and lanes leave the pending set only. No lane joins it between acceptances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_start | input | 1 | Offers a new group; it is taken when busy is low |
| lane_valid | input | LANES | Per-lane request valid |
| lane_we | input | LANES | Per-lane write enable (1 = write, 0 = read) |
| lane_addr | input | LANES*14 | Per-lane byte address, lane l at bits [14l+13:14l] |
| lane_wdata | input | LANES*32 | Per-lane write data, lane l at bits [32l+31:32l] |
| busy | output | 1 | A group is in progress; new starts are ignored |
| done | output | 1 | One-cycle pulse when the group is finished |
| rd_valid | output | LANES | Per-lane read data valid pulse |
| rd_data | output | LANES*32 | Per-lane read data, same lane packing as lane_wdata |

## Verification
The in-RTL assertions check the following on every cycle:
- Each bank grants at most one lane per pass.
- Every busy pass removes at least one lane from the pending set.
- A start that arrives while busy adds no lane to that set.
- `done` and `rd_valid` only appear while busy, and busy only falls right after `done`.

Some properties need the bench's scenarios instead:
- Lowest-lane-first ordering.
- Which write survives a same-word collision.
- The exact pass count for each stride and conflict pattern.
- The four-cycle read return.

For these the bench keeps a word-level model of the memory and replays each group pass by pass.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // Default geometry of the scratchpad
    localparam int SP_LANES      = 16;
    localparam int SP_BANKS      = 16;
    localparam int SP_BANK_WORDS = 256;
    localparam int SP_DATA_W     = 32;
    localparam int SP_READ_LAT   = 4;
endpackage

// File: rtl/sp_bank_arb.sv
// Per-bank arbiter: each bank picks its lowest-numbered pending lane.
module sp_bank_arb #(
    parameter  int LANES  = sp_pkg::SP_LANES,
    parameter  int BANKS  = sp_pkg::SP_BANKS,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             pend,
    input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
    output logic [LANES-1:0]             grant,
    output logic [BANKS-1:0]             bank_en,
    output logic [BANKS-1:0][LANE_W-1:0] bank_sel
);

    // Scan lanes from high to low so the lowest pending lane wins
    always_comb begin
        bank_en  = '0;
        bank_sel = '0;
        for (int b = 0; b < BANKS; b++) begin
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pend[l] && lane_bank[l] == BANK_W'(b)) begin
                    bank_en[b]  = 1'b1;
                    bank_sel[b] = LANE_W'(l);
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            grant[l] = pend[l] && bank_en[lane_bank[l]]
                       && (bank_sel[lane_bank[l]] == LANE_W'(l));
        end
    end

    // Serialization guard: one lane per bank per pass
    for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
        logic [LANES-1:0] in_bank;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign in_bank[l] = (lane_bank[l] == BANK_W'(b));
        end
        assert_one_grant_per_bank_R4 : assert property (
            @(posedge clk) disable iff (!rst_n)
            $countones(grant & in_bank) <= 1
        );
    end

    // Every pass makes progress
    assert_pass_progress_R11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (|pend) |-> (|grant)
    );

endmodule

// File: rtl/sp_bank.sv
// One bank: single port, write or synchronous read per cycle, no reset on contents.
module sp_bank #(
    parameter  int WORDS  = sp_pkg::SP_BANK_WORDS,
    parameter  int DATA_W = sp_pkg::SP_DATA_W,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[idx] <= wdata;
        end
        if (en && !we) begin
            rdata_q <= mem[idx];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sp_rd_pipe.sv
// Fixed-depth delay line for per-lane read data and valid.
module sp_rd_pipe #(
    parameter int LANES  = sp_pkg::SP_LANES,
    parameter int DATA_W = sp_pkg::SP_DATA_W,
    parameter int DEPTH  = sp_pkg::SP_READ_LAT - 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             in_vld,
    input  logic [LANES-1:0][DATA_W-1:0] in_data,
    output logic [LANES-1:0]             out_vld,
    output logic [LANES-1:0][DATA_W-1:0] out_data
);

    typedef struct packed {
        logic [DEPTH-1:0][LANES-1:0]             vld;
        logic [DEPTH-1:0][LANES-1:0][DATA_W-1:0] data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d.vld[0]  = in_vld;
        pipe_d.data[0] = in_data;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d.vld[i]  = pipe_q.vld[i-1];
            pipe_d.data[i] = pipe_q.data[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_vld  = pipe_q.vld[DEPTH-1];
    assign out_data = pipe_q.data[DEPTH-1];

endmodule

// File: rtl/sp_banked_scratch.sv
// Multi-lane banked scratchpad that serializes same-bank requests over passes.
module sp_banked_scratch #(
    parameter  int LANES      = sp_pkg::SP_LANES,
    parameter  int BANKS      = sp_pkg::SP_BANKS,
    parameter  int BANK_WORDS = sp_pkg::SP_BANK_WORDS,
    parameter  int DATA_W     = sp_pkg::SP_DATA_W,
    parameter  int READ_LAT   = sp_pkg::SP_READ_LAT,
    localparam int OFS_W      = $clog2(DATA_W / 8),
    localparam int BANK_W     = $clog2(BANKS),
    localparam int IDX_W      = $clog2(BANK_WORDS),
    localparam int ADDR_W     = OFS_W + BANK_W + IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grp_start,
    input  logic [LANES-1:0]          lane_valid,
    input  logic [LANES-1:0]          lane_we,
    input  logic [LANES*ADDR_W-1:0]   lane_addr,
    input  logic [LANES*DATA_W-1:0]   lane_wdata,
    output logic                      busy,
    output logic                      done,
    output logic [LANES-1:0]          rd_valid,
    output logic [LANES*DATA_W-1:0]   rd_data
);

    localparam int LANE_W  = $clog2(LANES);
    localparam int WADDR_W = ADDR_W - OFS_W;
    localparam int CNT_W   = $clog2(READ_LAT);

    typedef struct packed {
        logic                          busy;
        logic                          done;
        logic [LANES-1:0]              pend;
        logic [CNT_W-1:0]              drain;
        logic [LANES-1:0]              we;
        logic [LANES-1:0][WADDR_W-1:0] waddr;
        logic [LANES-1:0][DATA_W-1:0]  wdata;
        logic [LANES-1:0]              rvld1;
        logic [LANES-1:0][BANK_W-1:0]  rbank1;
    } state_t;

    state_t st_d, st_q;

    logic                         accept;
    logic [LANES-1:0][BANK_W-1:0] lane_bank;
    logic [LANES-1:0]             grant;
    logic [BANKS-1:0]             bank_en;
    logic [BANKS-1:0][LANE_W-1:0] bank_sel;
    logic [BANKS-1:0]             b_we;
    logic [BANKS-1:0][IDX_W-1:0]  b_idx;
    logic [BANKS-1:0][DATA_W-1:0] b_wdata;
    logic [BANKS-1:0][DATA_W-1:0] b_rdata;
    logic [LANES-1:0][DATA_W-1:0] stage1_data;
    logic [LANES-1:0][DATA_W-1:0] out_data;
    logic [LANES-1:0][OFS_W-1:0]  byte_ofs;
    logic                         unused_byte_ofs;

    assign accept = grp_start && !st_q.busy;

    // Address split: bank from the low word bits, entry from the rest
    for (genvar l = 0; l < LANES; l++) begin : g_lane_map
        assign lane_bank[l] = st_q.waddr[l][BANK_W-1:0];
        assign byte_ofs[l]  = lane_addr[l*ADDR_W +: OFS_W];
    end
    assign unused_byte_ofs = ^byte_ofs;

    sp_bank_arb #(
        .LANES (LANES),
        .BANKS (BANKS)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (st_q.pend),
        .lane_bank (lane_bank),
        .grant     (grant),
        .bank_en   (bank_en),
        .bank_sel  (bank_sel)
    );

    // Route the winning lane of each bank to that bank's port
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            b_we[b]    = st_q.we[bank_sel[b]];
            b_idx[b]   = st_q.waddr[bank_sel[b]][BANK_W +: IDX_W];
            b_wdata[b] = st_q.wdata[bank_sel[b]];
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sp_bank #(
            .WORDS  (BANK_WORDS),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk   (clk),
            .en    (bank_en[b]),
            .we    (b_we[b]),
            .idx   (b_idx[b]),
            .wdata (b_wdata[b]),
            .rdata (b_rdata[b])
        );
    end

    // Steer bank outputs back to the lanes that read them one cycle ago
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            stage1_data[l] = b_rdata[st_q.rbank1[l]];
        end
    end

    sp_rd_pipe #(
        .LANES  (LANES),
        .DATA_W (DATA_W),
        .DEPTH  (READ_LAT - 1)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (st_q.rvld1),
        .in_data  (stage1_data),
        .out_vld  (rd_valid),
        .out_data (out_data)
    );

    assign rd_data = out_data;

    // Next-state logic
    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.rvld1  = grant & ~st_q.we;
        st_d.rbank1 = lane_bank;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.pend  = lane_valid;
            st_d.we    = lane_we;
            st_d.wdata = lane_wdata;
            st_d.drain = CNT_W'(READ_LAT - 1);
            for (int l = 0; l < LANES; l++) begin
                st_d.waddr[l] = lane_addr[l*ADDR_W + OFS_W +: WADDR_W];
            end
        end else if (st_q.busy) begin
            if (|st_q.pend) begin
                st_d.pend  = st_q.pend & ~grant;
                st_d.drain = CNT_W'(READ_LAT - 1);
            end else if (st_q.drain == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.drain = st_q.drain - CNT_W'(1);
                if (st_q.drain == CNT_W'(1)) begin
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    assert_done_in_busy_R8 : assert property (
        @(posedge clk) disable iff (!rst_n)
        done |-> busy
    );

    assert_busy_ends_on_done_R8 : assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)
    );

    assert_start_ignored_busy_R2 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q.busy && grp_start) |=> ((st_q.pend & ~$past(st_q.pend)) == '0)
    );

    assert_pend_shrinks_R11 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q.busy && (|st_q.pend)) |=> (st_q.pend != $past(st_q.pend))
    );

    assert_rdvalid_in_busy_R6 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (|rd_valid) |-> busy
    );

endmodule

// File: tb/sp_banked_scratch_tb.sv
module sp_banked_scratch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              grp_start = 1'b0;
    logic [NL-1:0]     lane_valid = '0;
    logic [NL-1:0]     lane_we = '0;
    logic [NL*14-1:0]  lane_addr = '0;
    logic [NL*32-1:0]  lane_wdata = '0;
    logic              busy, done;
    logic [NL-1:0]     rd_valid;
    logic [NL*32-1:0]  rd_data;

    int checks = 0;
    int fails  = 0;

    bit [NL-1:0]   v, w;
    logic [13:0]   a [NL];
    logic [31:0]   d [NL];
    logic [31:0]   mdl [4096];
    logic [31:0]   seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_banked_scratch u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_start  (grp_start),
        .lane_valid (lane_valid),
        .lane_we    (lane_we),
        .lane_addr  (lane_addr),
        .lane_wdata (lane_wdata),
        .busy       (busy),
        .done       (done),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one group from v/w/a/d, predict every cycle, compare at negedges.
    task automatic run_group(input string tag, input bit stray);
        int rank [NL];
        int npass = 0;
        logic [31:0] exp_rd [NL];
        for (int l = 0; l < NL; l++) begin
            rank[l] = 0;
            exp_rd[l] = '0;
            if (v[l]) begin
                rank[l] = 1;
                for (int k = 0; k < l; k++)
                    if (v[k] && a[k][5:2] == a[l][5:2]) rank[l]++;
                if (rank[l] > npass) npass = rank[l];
            end
        end
        for (int p = 1; p <= npass; p++) begin
            for (int l = 0; l < NL; l++) begin
                if (rank[l] == p) begin
                    if (w[l]) mdl[a[l][13:2]] = d[l];
                    else      exp_rd[l] = mdl[a[l][13:2]];
                end
            end
        end
        grp_start  = 1'b1;
        lane_valid = v;
        lane_we    = w;
        for (int l = 0; l < NL; l++) begin
            lane_addr[l*14 +: 14]  = a[l];
            lane_wdata[l*32 +: 32] = d[l];
        end
        for (int c = 1; c <= npass + 5; c++) begin
            @(negedge clk);
            grp_start = 1'b0;
            if (stray && c == 2) begin
                grp_start  = 1'b1;
                lane_valid = '1;
                lane_we    = '1;
                for (int l = 0; l < NL; l++) begin
                    lane_addr[l*14 +: 14]  = 14'(l * 4);
                    lane_wdata[l*32 +: 32] = 32'hDEAD_BEEF;
                end
            end
            chk(busy == (c <= npass + 4), "R8 busy", 64'(busy), 64'(c <= npass + 4));
            chk(done == (c == npass + 4), tag, 64'(done), 64'(c == npass + 4));
            begin
                logic [NL-1:0] ev;
                for (int l = 0; l < NL; l++)
                    ev[l] = v[l] && !w[l] && (rank[l] + 4 == c);
                chk(rd_valid == ev, "R6 rd_valid", 64'(rd_valid), 64'(ev));
                for (int l = 0; l < NL; l++)
                    if (ev[l])
                        chk(rd_data[l*32 +: 32] == exp_rd[l], tag,
                            64'(rd_data[l*32 +: 32]), 64'(exp_rd[l]));
            end
        end
    endtask

    task automatic clear_lanes();
        v = '0;
        w = '0;
        for (int l = 0; l < NL; l++) begin
            a[l] = '0;
            d[l] = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && rd_valid == '0, "R9 during reset", {busy, done, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && rd_valid == '0, "R9 after reset", {busy, done, rd_valid}, 0);

        // R3: fill the whole memory, 16 consecutive words per group, one pass each
        for (int g = 0; g < 256; g++) begin
            v = '1;
            w = '1;
            for (int l = 0; l < NL; l++) begin
                a[l] = 14'((g * 16 + l) * 4);
                d[l] = 32'((g * 16 + l) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
            end
            run_group("R3 fill", 1'b0);
        end

        // R4: stride sweep, pure reads then mixed read/write
        for (int k = 1; k <= 16; k++) begin
            for (int ph = 0; ph < 2; ph++) begin
                v = '1;
                for (int l = 0; l < NL; l++) begin
                    w[l] = (ph == 1) && l[0];
                    a[l] = 14'(((k * 37 + l * k) % 4096) * 4);
                    d[l] = rnd();
                end
                run_group("R4 stride", 1'b0);
            end
        end

        // R1: byte offset ignored, and a run that wraps from bank 15 to bank 0
        v = '1;
        w = '0;
        for (int l = 0; l < NL; l++) begin
            a[l] = 14'((200 + l) * 4 + (l % 4));
            d[l] = '0;
        end
        run_group("R1 offset", 1'b0);
        for (int l = 0; l < NL; l++) a[l] = 14'((14 + l) * 4);
        run_group("R1 wrap", 1'b0);

        // R5: lane order within a bank
        clear_lanes();
        v[2] = 1'b1; w[2] = 1'b1; a[2] = 14'(100 * 4); d[2] = 32'hA5A5_0001;
        v[9] = 1'b1;              a[9] = 14'(100 * 4);
        v[1] = 1'b1;              a[1] = 14'(201 * 4);
        v[5] = 1'b1; w[5] = 1'b1; a[5] = 14'(201 * 4); d[5] = 32'hB6B6_0002;
        run_group("R5 order", 1'b0);

        // R7: every lane writes one word, then read it back
        v = '1;
        w = '1;
        for (int l = 0; l < NL; l++) begin
            a[l] = 14'(300 * 4);
            d[l] = 32'(l + 256);
        end
        run_group("R7 collide", 1'b0);
        clear_lanes();
        v[0] = 1'b1;
        a[0] = 14'(300 * 4);
        run_group("R7 readback", 1'b0);

        // R2: a start while busy must be ignored
        clear_lanes();
        for (int l = 0; l < 4; l++) begin
            v[l] = 1'b1;
            a[l] = 14'((40 + l * 16) * 4);
        end
        run_group("R2 busy", 1'b1);
        v = '1;
        w = '0;
        for (int l = 0; l < NL; l++) a[l] = 14'(l * 4);
        run_group("R2 readback", 1'b0);

        // R10: a group with no valid lanes, its writes must not land
        v = '0;
        w = '1;
        for (int l = 0; l < NL; l++) begin
            a[l] = 14'(l * 4);
            d[l] = 32'hFFFF_0000;
        end
        run_group("R10 empty", 1'b0);
        v = '1;
        w = '0;
        run_group("R10 readback", 1'b0);

        // R10 / R11: pseudo-random masks over a small, conflict-heavy window
        for (int g = 0; g < 300; g++) begin
            logic [31:0] m;
            m = rnd();
            v = m[15:0];
            w = m[31:16];
            for (int l = 0; l < NL; l++) begin
                logic [31:0] r;
                r = rnd();
                a[l] = {6'(r[5:0]), r[9:8]} + 14'(0);
                a[l] = 14'({r[5:0], 2'b00}) | 14'(r[9:8]);
                d[l] = rnd();
            end
            run_group((g % 2 == 0) ? "R10 random" : "R11 random", 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule